// File: doc/BRIEF.md
# Power-Up Configuration Loader with Two-Wire EEPROM Master

This block runs once after every reset. Two strap inputs are captured in the first clock cycle after reset release. The first strap decides whether a load happens at all. The second picks one of two serial EEPROM flavours, which differ in device address and in subaddress width.

When loading is enabled, a built-in two-wire master takes these steps:
- It selects subaddress zero with a write transfer.
- It issues a repeated start and reads sequentially.
- It treats the first byte as a length.
- It streams up to `DEPTH` following bytes into a local register file.
- It closes the transfer with a stop condition.

If the EEPROM does not acknowledge, the loader stops the bus and flags that defaults stay in force. It does not raise an error. Only when the sequence is over does the block assert its attach enable, which turns on the pull-up that announces the device to the host.

The register-file write port is a valid/ready stream. While `cfg_wr_valid` is high and `cfg_wr_ready` is low, the address and data are held, and the serial clock stays low. The EEPROM therefore simply waits, and no byte is lost or repeated. Bit timing comes from `QCYC`, the number of clock cycles per quarter serial bit. A value of 62 at 100 MHz gives about 400 kHz, and 250 gives 100 kHz. While the master releases SCL, a device holding SCL low stretches the bit.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: With `strap_load_en` = 0 at reset release, `load_done` and `attach_en` rise within 3 cycles of reset release, SCL and SDA are never pulled low, no register write occurs and `defaults_used` = 1.
- R2: With `strap_narrow_eeprom` = 1 the master addresses 7-bit device 0x51 and sends exactly one subaddress byte, 0x00.
- R3: With `strap_narrow_eeprom` = 0 the master addresses 7-bit device 0x50 and sends exactly two subaddress bytes, both 0x00.
- R4: Both straps are captured only in the first cycle after reset release; later changes have no effect until the next reset.
- R5: `attach_en` and `load_done` are 0 during reset and throughout the bus sequence, rise together when it ends, stay 1 until reset, and the bus is never pulled while they are 1.
- R6: A NACK on the address or a subaddress byte ends the transfer with a stop condition; the block then finishes with `defaults_used` = 1 and no register write.
- R7: After a repeated start with the read address, the first byte read is a count N; min(N, `DEPTH`) following bytes are written to register addresses 0, 1, 2, … in order, and `defaults_used` = 0.
- R8: Every byte read is acknowledged except the last one (the count byte itself when N = 0), which is NACKed and followed by a stop condition that leaves both lines released.
- R9: A register write completes in a cycle where `cfg_wr_valid` and `cfg_wr_ready` are both 1. While `cfg_wr_valid` = 1 and `cfg_wr_ready` = 0, the address and data stay stable and SCL is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_load_en | input | 1 | 1: load from EEPROM, 0: skip loading |
| strap_narrow_eeprom | input | 1 | 1: device 0x51 with 1-byte subaddress, 0: device 0x50 with 2-byte subaddress |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| scl_oe | output | 1 | 1 pulls the serial clock line low |
| sda_oe | output | 1 | 1 pulls the serial data line low |
| cfg_wr_valid | output | 1 | Register write request |
| cfg_wr_ready | input | 1 | Register file accepts the write |
| cfg_wr_addr | output | $clog2(DEPTH) | Register write address |
| cfg_wr_data | output | 8 | Register write data |
| load_done | output | 1 | Loading sequence finished |
| defaults_used | output | 1 | Loading skipped or EEPROM absent |
| attach_en | output | 1 | Enables the host-bus attach pull-up |

## Verification
The bench models a byte-addressed EEPROM that decodes the waveform on the two lines. A wrong device address, a missing or extra subaddress byte, or a misplaced ACK therefore shows up within one serial byte, as a NACK-driven fallback or as a wrong count of ACKs and NACKs. If the sequencer loses track of the length or the write index, the register-file stream shows a wrong count, a wrong order or wrong data by the time `load_done` rises. If the handshake is corrupted, the stalled address or data changes while `cfg_wr_ready` is low. A wrong done state shows as `attach_en` rising early, never rising, or coinciding with bus activity.

// File: rtl/cfg_ldr_pkg.sv
package cfg_ldr_pkg;
  typedef enum logic [1:0] {BIT_START, BIT_STOP, BIT_DATA} bit_op_e;
  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_WR, CMD_RD} byte_cmd_e;
  typedef enum logic [3:0] {
    S_SAMPLE, S_START, S_DEVW, S_SUBH, S_SUBL, S_RSTART,
    S_DEVR, S_CNT, S_DATA, S_STOP, S_DONE
  } seq_state_e;
  localparam logic [6:0] DEV_NARROW = 7'h51;
  localparam logic [6:0] DEV_WIDE   = 7'h50;
endpackage

// File: rtl/cfg_ldr_bitphy.sv
// One serial bit slot (start, stop or data) split into four quarters.
module cfg_ldr_bitphy import cfg_ldr_pkg::*; #(
  parameter int QCYC = 62,
  localparam int CW = (QCYC > 1) ? $clog2(QCYC) : 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    op_valid,
  output logic    op_ready,
  input  bit_op_e op_kind,
  input  logic    op_bit,
  output logic    op_done,
  output logic    rx_bit,
  input  logic    scl_i,
  input  logic    sda_i,
  output logic    scl_oe,
  output logic    sda_oe
);
  logic          busy;
  bit_op_e       kind;
  logic          bitv;
  logic [1:0]    q;
  logic [CW-1:0] cnt;
  logic          scl_h, sda_h, scl_now, sda_now;
  logic          q_end, stretched;

  always_comb begin
    case (kind)
      BIT_START: begin scl_now = (q == 2'd0) || (q == 2'd3); sda_now = (q >= 2'd2); end
      BIT_STOP:  begin scl_now = (q == 2'd0);                sda_now = (q <= 2'd1); end
      default:   begin scl_now = (q == 2'd0) || (q == 2'd3); sda_now = !bitv;        end
    endcase
  end

  assign scl_oe    = busy ? scl_now : scl_h;
  assign sda_oe    = busy ? sda_now : sda_h;
  assign op_ready  = !busy;
  assign stretched = ((q == 2'd1) || (q == 2'd2)) && !scl_i;
  assign q_end     = (cnt == CW'(QCYC - 1)) && !stretched;
  assign op_done   = busy && (q == 2'd3) && q_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; kind <= BIT_DATA; bitv <= 1'b1; q <= 2'd0; cnt <= '0;
      rx_bit <= 1'b1; scl_h <= 1'b0; sda_h <= 1'b0;
    end else if (!busy) begin
      if (op_valid) begin
        busy <= 1'b1; kind <= op_kind; bitv <= op_bit; q <= 2'd0; cnt <= '0;
      end
    end else if (!stretched) begin
      if (q_end) begin
        cnt <= '0;
        q   <= q + 2'd1;
        if (q == 2'd2) rx_bit <= sda_i;
        if (q == 2'd3) begin
          busy <= 1'b0; scl_h <= scl_now; sda_h <= sda_now;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Between slots the lines keep their last level (SCL low while paused).
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !op_valid) |=> ($stable(scl_oe) && $stable(sda_oe)));
endmodule

// File: rtl/cfg_ldr_byteio.sv
// Byte layer: start/stop, 9-slot write, 8-slot read plus caller-chosen ACK.
module cfg_ldr_byteio import cfg_ldr_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  output logic      cmd_ready,
  input  byte_cmd_e cmd_kind,
  input  logic [7:0] cmd_data,
  output logic      cmd_done,
  output logic [7:0] rx_data,
  output logic      rx_ack,
  output logic      rd_wait,
  input  logic      ack_go,
  input  logic      ack_nack,
  output logic      op_valid,
  input  logic      op_ready,
  output bit_op_e   op_kind,
  output logic      op_bit,
  input  logic      op_done,
  input  logic      rx_bit
);
  logic       active, issued, waiting, nackbit;
  byte_cmd_e  kind;
  logic [7:0] sh;
  logic [3:0] bitn;
  logic       single;

  assign single    = (kind == CMD_START) || (kind == CMD_STOP);
  assign cmd_ready = !active;
  assign op_valid  = active && !issued && !waiting;
  assign op_kind   = (kind == CMD_START) ? BIT_START :
                     (kind == CMD_STOP)  ? BIT_STOP  : BIT_DATA;
  assign op_bit    = (kind == CMD_WR) ? ((bitn < 4'd8) ? sh[7] : 1'b1)
                                      : ((bitn < 4'd8) ? 1'b1  : nackbit);
  assign cmd_done  = active && op_done && (single || (bitn == 4'd8));
  assign rx_data   = sh;
  assign rx_ack    = !rx_bit;
  assign rd_wait   = waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; kind <= CMD_START; sh <= '0; bitn <= '0;
      issued <= 1'b0; waiting <= 1'b0; nackbit <= 1'b0;
    end else if (!active) begin
      if (cmd_valid) begin
        active <= 1'b1; kind <= cmd_kind; sh <= cmd_data; bitn <= '0;
        issued <= 1'b0; nackbit <= 1'b0;
      end
    end else begin
      if (op_valid && op_ready) issued <= 1'b1;
      if (waiting && ack_go) begin
        waiting <= 1'b0; nackbit <= ack_nack;
      end
      if (op_done) begin
        issued <= 1'b0;
        if (single) begin
          active <= 1'b0;
        end else begin
          if (bitn < 4'd8) sh <= {sh[6:0], rx_bit};
          if (bitn == 4'd8) active <= 1'b0;
          else              bitn   <= bitn + 4'd1;
          if ((kind == CMD_RD) && (bitn == 4'd7)) waiting <= 1'b1;
        end
      end
    end
  end

  // While a read byte waits for its ACK decision the bit layer is idle.
  assert_wait_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait |-> op_ready);
endmodule

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader import cfg_ldr_pkg::*; #(
  parameter int QCYC  = 62,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_load_en,
  input  logic          strap_narrow_eeprom,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          cfg_wr_valid,
  input  logic          cfg_wr_ready,
  output logic [AW-1:0] cfg_wr_addr,
  output logic [7:0]    cfg_wr_data,
  output logic          load_done,
  output logic          defaults_used,
  output logic          attach_en
);
  seq_state_e st;
  logic          en_q, narrow_q, sent, last_nack, dflt, done_q;
  logic [NW-1:0] n_q, idx, idx_nx, cap;
  logic          cmd_valid, cmd_ready, cmd_done, rx_ack, rd_wait, ack_go, ack_nack;
  byte_cmd_e     cmd_kind;
  logic [7:0]    cmd_data, rx_data;
  logic          op_valid, op_ready, op_bit, op_done, rx_bit;
  bit_op_e       op_kind;
  logic [6:0]    dev;

  assign dev    = narrow_q ? DEV_NARROW : DEV_WIDE;
  assign idx_nx = idx + 1'b1;
  assign cap    = (rx_data > 8'(DEPTH)) ? NW'(DEPTH) : NW'(rx_data);

  always_comb begin
    cmd_kind = CMD_WR;
    cmd_data = 8'h00;
    case (st)
      S_START, S_RSTART: cmd_kind = CMD_START;
      S_STOP:            cmd_kind = CMD_STOP;
      S_DEVW:            cmd_data = {dev, 1'b0};
      S_DEVR:            cmd_data = {dev, 1'b1};
      S_CNT, S_DATA:     cmd_kind = CMD_RD;
      default: ;
    endcase
  end

  assign cmd_valid    = !sent && (st != S_SAMPLE) && (st != S_DONE);
  assign cfg_wr_valid = (st == S_DATA) && rd_wait;
  assign cfg_wr_addr  = idx[AW-1:0];
  assign cfg_wr_data  = rx_data;
  assign ack_go       = (st == S_CNT) ? rd_wait : (cfg_wr_valid && cfg_wr_ready);
  assign ack_nack     = (st == S_CNT) ? (cap == '0) : (idx_nx == n_q);
  assign load_done     = done_q;
  assign attach_en     = done_q;
  assign defaults_used = dflt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SAMPLE; en_q <= 1'b0; narrow_q <= 1'b0; n_q <= '0; idx <= '0;
      sent <= 1'b0; last_nack <= 1'b0; dflt <= 1'b0; done_q <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) sent <= 1'b1;
      if (cmd_done) sent <= 1'b0;
      case (st)
        S_SAMPLE: begin
          en_q <= strap_load_en; narrow_q <= strap_narrow_eeprom;
          if (strap_load_en) st <= S_START;
          else begin dflt <= 1'b1; st <= S_DONE; end
        end
        S_CNT:  if (rd_wait) begin n_q <= cap; last_nack <= (cap == '0); end
        S_DATA: if (ack_go)  begin idx <= idx_nx; last_nack <= (idx_nx == n_q); end
        S_DONE: done_q <= 1'b1;
        default: ;
      endcase
      if (cmd_done) begin
        case (st)
          S_START:  st <= S_DEVW;
          S_DEVW:   if (rx_ack) st <= narrow_q ? S_SUBL : S_SUBH;
                    else begin dflt <= 1'b1; st <= S_STOP; end
          S_SUBH:   if (rx_ack) st <= S_SUBL;
                    else begin dflt <= 1'b1; st <= S_STOP; end
          S_SUBL:   if (rx_ack) st <= S_RSTART;
                    else begin dflt <= 1'b1; st <= S_STOP; end
          S_RSTART: st <= S_DEVR;
          S_DEVR:   if (rx_ack) st <= S_CNT;
                    else begin dflt <= 1'b1; st <= S_STOP; end
          S_CNT, S_DATA: st <= last_nack ? S_STOP : S_DATA;
          S_STOP:   st <= S_DONE;
          default: ;
        endcase
      end
    end
  end

  cfg_ldr_byteio u_byte (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_kind, .cmd_data, .cmd_done,
    .rx_data, .rx_ack, .rd_wait, .ack_go, .ack_nack,
    .op_valid, .op_ready, .op_kind, .op_bit, .op_done, .rx_bit
  );

  cfg_ldr_bitphy #(.QCYC(QCYC)) u_phy (
    .clk, .rst_n, .op_valid, .op_ready, .op_kind, .op_bit, .op_done, .rx_bit,
    .scl_i, .sda_i, .scl_oe, .sda_oe
  );

  assert_no_traffic_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_SAMPLE && !en_q) |-> (!scl_oe && !sda_oe));
  assert_strap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_SAMPLE) |=> ($stable(en_q) && $stable(narrow_q)));
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> (load_done && attach_en));
  assert_quiet_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
    attach_en |-> (!scl_oe && !sda_oe));
  assert_wr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_valid |-> (idx < n_q));
  assert_wr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_valid && !cfg_wr_ready) |=>
      (cfg_wr_valid && $stable(cfg_wr_addr) && $stable(cfg_wr_data)));
  assert_scl_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_valid |-> scl_oe);
endmodule

// File: tb/cfg_eeprom_loader_tb_top.sv
module cfg_eeprom_loader_tb_top;
  localparam int QCYC = 3;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_en = 1'b0, strap_narrow = 1'b0;
  logic scl_oe, sda_oe, wr_valid, wr_ready = 1'b1, load_done, dflt, attach_en;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic sl_low = 1'b0;
  wire scl_w = !scl_oe;
  wire sda_w = !(sda_oe || sl_low);

  always #5 clk = !clk;

  cfg_eeprom_loader #(.QCYC(QCYC), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_load_en(strap_en), .strap_narrow_eeprom(strap_narrow),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cfg_wr_valid(wr_valid), .cfg_wr_ready(wr_ready), .cfg_wr_addr(wr_addr),
    .cfg_wr_data(wr_data), .load_done(load_done), .defaults_used(dflt), .attach_en(attach_en)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // EEPROM model settings (written only by the stimulus).
  logic [7:0] mem [256];
  bit sl_on = 0, sl_is51 = 0, rnd_ready = 0;

  // EEPROM model state.
  localparam int P_IDLE = 0, P_ADDR = 1, P_SUBH = 2, P_SUBL = 3, P_READ = 4, P_WAIT = 5;
  int phase = P_IDLE, bitcnt = 0, sub_n = 0, sub_bad = 0, acks = 0, nacks = 0, stops = 0;
  bit ack_pend = 0, prev_scl = 1, prev_sda = 1;
  logic [7:0] sh = 0, outb = 0, ptr = 0;

  always @(scl_w, sda_w, rst_n) begin
    if (!rst_n) begin
      phase = P_IDLE; bitcnt = 0; sub_n = 0; sub_bad = 0; acks = 0; nacks = 0;
      stops = 0; ack_pend = 0; ptr = 0; sl_low = 0; prev_scl = 1; prev_sda = 1;
    end else begin
      if (scl_w && prev_scl && !sda_w && prev_sda) begin
        phase = P_ADDR; bitcnt = 0; ack_pend = 0;
      end else if (scl_w && prev_scl && sda_w && !prev_sda) begin
        phase = P_IDLE; stops++; sl_low = 0;
      end else if (scl_w && !prev_scl && phase != P_IDLE) begin
        if (bitcnt == 8) begin
          if (ack_pend) ack_pend = 0;
          else if (phase == P_READ) begin
            if (!sda_w) begin acks++; ptr = ptr + 8'd1; outb = mem[ptr]; end
            else begin nacks++; phase = P_WAIT; end
          end
          bitcnt = 0;
        end else if (phase != P_WAIT) begin
          if (phase != P_READ) sh = {sh[6:0], sda_w};
          bitcnt++;
          if (bitcnt == 8 && phase != P_READ) begin
            case (phase)
              P_ADDR: if (sl_on && sh[7:1] == (sl_is51 ? 7'h51 : 7'h50)) begin
                        ack_pend = 1;
                        if (sh[0]) begin phase = P_READ; outb = mem[ptr]; end
                        else phase = sl_is51 ? P_SUBL : P_SUBH;
                      end else phase = P_WAIT;
              P_SUBH: begin sub_n++; if (sh != 0) sub_bad++; ack_pend = 1; phase = P_SUBL; end
              P_SUBL: begin sub_n++; if (sh != 0) sub_bad++; ptr = sh; ack_pend = 1; phase = P_WAIT; end
              default: ;
            endcase
          end
        end
      end else if (!scl_w && prev_scl) begin
        if (phase != P_IDLE && bitcnt == 8 && ack_pend) sl_low = 1;
        else if (phase == P_READ && bitcnt < 8) sl_low = !outb[7 - bitcnt];
        else sl_low = 0;
      end
      prev_scl = scl_w;
      prev_sda = sda_w;
    end
  end

  // Register-file side: capture, ordering, stall stability, bus activity.
  logic [7:0] got [DEPTH];
  int wcount = 0, order_err = 0, stall_err = 0, traffic = 0, late_traffic = 0;
  bit stalled = 0;
  logic [AW-1:0] st_addr = 0;
  logic [7:0] st_data = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      wcount <= 0; order_err <= 0; stall_err <= 0; traffic <= 0; late_traffic <= 0; stalled <= 0;
    end else begin
      if (stalled && (!wr_valid || wr_addr != st_addr || wr_data != st_data)) stall_err <= stall_err + 1;
      stalled <= wr_valid && !wr_ready;
      st_addr <= wr_addr; st_data <= wr_data;
      if (wr_valid && wr_ready) begin
        got[wr_addr] <= wr_data;
        if (int'(wr_addr) != wcount) order_err <= order_err + 1;
        wcount <= wcount + 1;
      end
      if (scl_oe || sda_oe) traffic <= traffic + 1;
      if (attach_en && (scl_oe || sda_oe)) late_traffic <= late_traffic + 1;
    end
  end

  always @(negedge clk) wr_ready <= rnd_ready ? (($urandom % 3) != 0) : 1'b1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input int cnt);
    return (cnt > DEPTH) ? DEPTH : cnt;
  endfunction

  task automatic run_case(input bit en, input bit narrow, input bit son, input bit s51,
                          input int cnt, input bit rnd, input bit flip);
    bit present;
    int n, lat, bad;
    present = en && son && (s51 == narrow);
    n = present ? exp_len(cnt) : 0;
    mem[0] = 8'(cnt);
    for (int i = 1; i < 256; i++) mem[i] = 8'($urandom);
    sl_on = son; sl_is51 = s51; rnd_ready = rnd;
    rst_n = 1'b0; strap_en = en; strap_narrow = narrow;
    repeat (3) @(negedge clk);
    chk(!load_done && !attach_en && !scl_oe && !sda_oe && !wr_valid, "R5", "reset state",
        {load_done, attach_en, scl_oe, sda_oe, wr_valid}, 0);
    rst_n = 1'b1;
    lat = 0;
    if (en) begin
      repeat (20) @(negedge clk);
      lat = 20;
      chk(!attach_en && !load_done, "R5", "attach during load", attach_en, 0);
      if (flip) begin strap_en = 1'b0; strap_narrow = !narrow; end
    end
    while (!load_done && lat < 30000) begin @(negedge clk); lat++; end
    chk(load_done == 1'b1, "R5", "load finished", load_done, 1);
    repeat (10) @(negedge clk);
    chk(attach_en && load_done, "R5", "attach held high", attach_en, 1);
    chk(late_traffic == 0, "R5", "bus pulled after attach", late_traffic, 0);
    chk(!scl_oe && !sda_oe, "R8", "bus released at end", {scl_oe, sda_oe}, 0);
    chk(dflt == !present, present ? "R7" : "R6", "defaults_used", dflt, !present);
    chk(wcount == n, "R7", "write count", wcount, n);
    bad = 0;
    for (int i = 0; i < n && i < DEPTH; i++) if (got[i] != mem[i + 1]) bad++;
    chk(bad == 0, "R7", "written data mismatches", bad, 0);
    chk(order_err == 0, "R7", "write order", order_err, 0);
    chk(stall_err == 0, "R9", "stall stability", stall_err, 0);
    if (!en) begin
      chk(traffic == 0, "R1", "bus activity with loading off", traffic, 0);
      chk(lat <= 3, "R1", "done latency", lat, 3);
    end else if (present) begin
      chk(sub_n == (narrow ? 1 : 2) && sub_bad == 0, narrow ? "R2" : "R3",
          "subaddress bytes", sub_n * 16 + sub_bad, narrow ? 16 : 32);
      chk(acks == n && nacks == 1, "R8", "read ACK/NACK pattern", acks * 16 + nacks, n * 16 + 1);
    end else begin
      chk(stops >= 1, "R6", "stop after NACK", stops, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    run_case(0, 1, 0, 1, 4, 0, 0);    // R1 loading off, no device
    run_case(0, 0, 1, 0, 4, 0, 0);    // R1 loading off, device present
    run_case(1, 1, 1, 1, 5, 0, 0);    // R2 narrow EEPROM
    run_case(1, 0, 1, 0, 7, 1, 0);    // R3 wide EEPROM with back-pressure (R9)
    run_case(1, 1, 1, 1, 0, 0, 0);    // R8 count zero: count byte NACKed
    run_case(1, 0, 1, 0, 200, 1, 0);  // R7 count capped at DEPTH
    run_case(1, 1, 1, 1, DEPTH, 0, 0);// R7 count exactly DEPTH
    run_case(1, 1, 0, 1, 5, 0, 0);    // R6 no device
    run_case(1, 1, 1, 0, 5, 0, 0);    // R6 device at other address
    run_case(1, 0, 1, 0, 6, 0, 1);    // R4 straps changed mid-load
    for (int k = 0; k < 5; k++) begin
      bit nr;
      nr = 1'($urandom);
      run_case(1, nr, 1, nr, int'($urandom % 24), 1, 0);
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule